// File: doc/BRIEF.md
# Interrupt Enable and Pending Register Bank

This block holds an enable bit and a pending bit for each of 134 interrupt lines, numbered 0 to 133. Software reaches the enable bits through a simple single-cycle register bus. There are two windows onto the same enable state. In the "set" window, writing a one turns a line on. In the "clear" window, writing a one turns a line off. In both windows a zero bit in the write data leaves its line alone, and reading either window returns the current enable state. Each 32-bit register word covers 32 consecutive lines, and the last word holds only six lines. Only privileged bus accesses take effect. An unprivileged access changes nothing, reads back zero and produces a one-cycle error pulse.

Each interrupt input is edge-detected. A rising edge marks the line pending whether or not the line is enabled. The eligibility mask sent to the downstream priority resolver is the pending state ANDed with the enable state. A disabled line therefore stays pending but is never offered for activation, until software enables it. When the resolver acknowledges a line by number, that line's pending bit is cleared.

Top module: `irq_en_bank`

## Requirements
- R1: After reset every enable bit and every pending bit is 0, so `eligible` is all zeros and every enable register reads 0.
- R2: A privileged write to set-window word k (byte address 0x100 + 4k) enables line 32k+n for each bit n that is 1 in the write data. Bits that are 0 have no effect.
- R3: A privileged read of set-window word k returns the enable state, with bit n of the word showing line 32k+n (1 = enabled). The result appears on `busRdata` combinationally, in the same cycle as the request.
- R4: A privileged write to clear-window word k (byte address 0x180 + 4k) disables line 32k+n for each bit n that is 1 and leaves the other lines unchanged. A read of the clear window returns the same enable state as the set window.
- R5: Writing zeros through the set window never clears an enable bit.
- R6: Word 4 (0x110 or 0x190) maps bits 5..0 to lines 128..133. Its bits 31..6 read as 0 and writes to them are ignored. Word offsets 5 to 31 inside either window read as 0.
- R7: An access with `busPriv` low leaves all enable bits unchanged and reads 0. It makes `accErr` high for exactly the one cycle after the access.
- R8: A rising edge on `irqIn[i]` sets line i pending one clock later, whether or not the line is enabled. An input held high does not set the line pending again.
- R9: `eligible[i]` is high exactly when line i is both pending and enabled. A line that became pending while disabled becomes eligible once it is enabled, and stops being eligible if it is disabled again.
- R10: `ackValid` with `ackId` = i clears line i's pending bit at the next clock. If a new rising edge on line i arrives in that same cycle, the line stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access request this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busPriv | input | 1 | 1 = privileged access |
| busAddr | input | 12 | Byte address of the register word |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data (combinational) |
| accErr | output | 1 | One-cycle pulse after an unprivileged access |
| irqIn | input | 134 | Interrupt input lines |
| ackValid | input | 1 | Activation acknowledge strobe |
| ackId | input | 8 | Number of the acknowledged line |
| eligible | output | 134 | Lines that are both pending and enabled |

## Verification
The assertions assume a single bus access per cycle with its controls stable around the clock edge. They also assume `ackId` names a line below 134 whenever `ackValid` is high. The stimulus meets both assumptions: it changes every input only on the falling clock edge, asserts `busSel` for exactly one cycle per access, and issues acknowledges only for lines it has actually raised. The interrupt inputs are held low through reset, so no line can show a spurious rising edge when reset is released.

// File: rtl/irq_en_pkg.sv
package irq_en_pkg;

  // A 0x80-byte window holds 32 register words
  localparam int WORD_IDX_W = 5;

  typedef struct packed {
    logic                  setEn;
    logic                  clrEn;
    logic                  rdEn;
    logic [WORD_IDX_W-1:0] word;
  } ctrlStrb_t;

endpackage

// File: rtl/irq_en_ctrl.sv
module irq_en_ctrl
  import irq_en_pkg::*;
#(
  parameter int                ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] SET_BASE = 'h100,
  parameter logic [ADDR_W-1:0] CLR_BASE = 'h180
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic              busPriv,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrb_t         strb,
  output logic              accErr
);

  localparam int WIN_LSB = WORD_IDX_W + 2;

  logic inSetWin;
  logic inClrWin;
  logic granted;

  assign inSetWin = busAddr[ADDR_W-1:WIN_LSB] == SET_BASE[ADDR_W-1:WIN_LSB];
  assign inClrWin = busAddr[ADDR_W-1:WIN_LSB] == CLR_BASE[ADDR_W-1:WIN_LSB];
  assign granted  = busSel && busPriv;

  always_comb begin
    strb.setEn = granted && busWrite && inSetWin;
    strb.clrEn = granted && busWrite && inClrWin;
    strb.rdEn  = granted && !busWrite && (inSetWin || inClrWin);
    strb.word  = busAddr[WIN_LSB-1:2];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) accErr <= 1'b0;
    else       accErr <= busSel && !busPriv;
  end

  // R7: error pulse follows an unprivileged access by one cycle
  a_r7_err_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busPriv) |=> accErr);
  a_r7_err_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && !busPriv) |=> !accErr);

endmodule

// File: rtl/irq_en_dpath.sv
module irq_en_dpath
  import irq_en_pkg::*;
#(
  parameter int NUM_IRQ = 134,
  parameter int DATA_W  = 32,
  parameter int ID_W    = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrb_t          strb,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic [NUM_IRQ-1:0] irqIn,
  input  logic               ackValid,
  input  logic [ID_W-1:0]    ackId,
  output logic [NUM_IRQ-1:0] eligible
);

  localparam int NUM_WORDS = (NUM_IRQ + DATA_W - 1) / DATA_W;
  localparam int PAD_W     = NUM_WORDS * DATA_W;

  logic [NUM_IRQ-1:0] enable;
  logic [NUM_IRQ-1:0] pending;
  logic [NUM_IRQ-1:0] irqPrev;
  logic [NUM_IRQ-1:0] irqRise;
  logic [PAD_W-1:0]   enPad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqPrev <= '0;
    else       irqPrev <= irqIn;
  end

  assign irqRise = irqIn & ~irqPrev;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : gLine
    localparam int WIDX = g / DATA_W;
    localparam int BIT  = g % DATA_W;
    logic hitWord;
    logic ackHit;

    assign hitWord = strb.word == WORD_IDX_W'(WIDX);
    assign ackHit  = ackValid && (ackId == ID_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enable[g] <= 1'b0;
      end else if (strb.setEn && hitWord && wdata[BIT]) begin
        enable[g] <= 1'b1;
      end else if (strb.clrEn && hitWord && wdata[BIT]) begin
        enable[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           pending[g] <= 1'b0;
      else if (irqRise[g]) pending[g] <= 1'b1;
      else if (ackHit)     pending[g] <= 1'b0;
    end
  end

  always_comb begin
    enPad = '0;
    enPad[NUM_IRQ-1:0] = enable;
  end

  always_comb begin
    rdata = '0;
    if (strb.rdEn && (32'(strb.word) < 32'(NUM_WORDS)))
      rdata = enPad[32'(strb.word)*DATA_W +: DATA_W];
  end

  assign eligible = pending & enable;

  // R5: no enable bit drops unless the clear window was written
  a_r5_set_never_clears: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clrEn |=> ((enable & $past(enable)) == $past(enable)));

  // R8: pending bits only fall on an acknowledge
  a_r8_pend_held: assert property (@(posedge clk) disable iff (!rstN)
    !ackValid |=> ((pending & $past(pending)) == $past(pending)));

endmodule

// File: rtl/irq_en_bank.sv
module irq_en_bank
  import irq_en_pkg::*;
#(
  parameter int NUM_IRQ = 134,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 12,
  parameter int ID_W    = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busWrite,
  input  logic               busPriv,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  output logic               accErr,
  input  logic [NUM_IRQ-1:0] irqIn,
  input  logic               ackValid,
  input  logic [ID_W-1:0]    ackId,
  output logic [NUM_IRQ-1:0] eligible
);

  localparam int LAST_WORD = (NUM_IRQ - 1) / DATA_W;
  localparam int LAST_BITS = NUM_IRQ - LAST_WORD * DATA_W;

  ctrlStrb_t strb;

  irq_en_ctrl #(
    .ADDR_W(ADDR_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busPriv(busPriv), .busAddr(busAddr), .strb(strb), .accErr(accErr)
  );

  irq_en_dpath #(
    .NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W), .ID_W(ID_W)
  ) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(busWdata), .rdata(busRdata),
    .irqIn(irqIn), .ackValid(ackValid), .ackId(ackId), .eligible(eligible)
  );

  // R7: unprivileged reads return zero
  a_r7_rd_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWrite && !busPriv) |-> (busRdata == '0));

  // R6: reserved upper bits of the last word read as zero
  a_r6_resv_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWrite && (32'(busAddr[6:2]) == 32'(LAST_WORD)))
      |-> ((busRdata >> LAST_BITS) == '0));

endmodule

// File: tb/tb_irq_en_bank.sv
module tb_irq_en_bank;

  localparam int NUM_IRQ = 134;
  localparam int NVEC    = 18;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         busSel = 1'b0, busWrite = 1'b0, busPriv = 1'b0;
  logic [11:0]  busAddr = '0;
  logic [31:0]  busWdata = '0;
  logic [31:0]  busRdata;
  logic         accErr;
  logic [133:0] irqIn = '0;
  logic         ackValid = 1'b0;
  logic [7:0]   ackId = '0;
  logic [133:0] eligible;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  irq_en_bank dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busPriv(busPriv), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .accErr(accErr), .irqIn(irqIn),
    .ackValid(ackValid), .ackId(ackId), .eligible(eligible)
  );

  // {isWrite, priv, addr, data}; data is write data or expected read data
  localparam logic [45:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 12'h100, 32'h0000_0000},  // R1 reset reads zero
    {1'b1, 1'b1, 12'h100, 32'h0000_00F1},  // R2 set lines 0,4..7
    {1'b0, 1'b1, 12'h100, 32'h0000_00F1},  // R3
    {1'b1, 1'b1, 12'h100, 32'h0000_0000},  // R5 zeros via set view
    {1'b0, 1'b1, 12'h100, 32'h0000_00F1},  // R5
    {1'b1, 1'b1, 12'h180, 32'h0000_0011},  // R4 clear lines 0,4
    {1'b0, 1'b1, 12'h180, 32'h0000_00E0},  // R4 clear view reads state
    {1'b0, 1'b1, 12'h100, 32'h0000_00E0},  // R4
    {1'b1, 1'b1, 12'h10C, 32'h8000_0001},  // R3 lines 96 and 127
    {1'b0, 1'b1, 12'h10C, 32'h8000_0001},  // R3
    {1'b1, 1'b1, 12'h110, 32'hFFFF_FFFF},  // R6 last word
    {1'b0, 1'b1, 12'h110, 32'h0000_003F},  // R6 reserved bits read 0
    {1'b1, 1'b1, 12'h190, 32'h0000_0021},  // R6 clear 128 and 133
    {1'b0, 1'b1, 12'h110, 32'h0000_001E},  // R6
    {1'b1, 1'b0, 12'h104, 32'hDEAD_0000},  // R7 unprivileged write
    {1'b0, 1'b1, 12'h104, 32'h0000_0000},  // R7 write had no effect
    {1'b0, 1'b0, 12'h100, 32'h0000_0000},  // R7 unprivileged read is 0
    {1'b0, 1'b1, 12'h114, 32'h0000_0000}   // R6 beyond last word
  };

  task automatic check(input bit ok, input string tag,
                       input logic [133:0] act, input logic [133:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic busOp(input logic wr, input logic pv, input logic [11:0] a,
                       input logic [31:0] d, output logic [31:0] rd);
    @(negedge clk);
    busSel = 1'b1; busWrite = wr; busPriv = pv; busAddr = a; busWdata = d;
    #1 rd = busRdata;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0; busPriv = 1'b0; busWdata = '0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    logic [31:0] dummy;
    busOp(1'b1, 1'b1, a, d, dummy);
  endtask

  function automatic logic [133:0] bitAt(input int n);
    logic [133:0] v;
    v = '0;
    v[n] = 1'b1;
    return v;
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state at the ports
    check(eligible == '0, "R1 eligible after reset", eligible, '0);
    check(accErr == 1'b0, "R1 accErr after reset", 134'(accErr), '0);

    // table-driven bus vectors (R2..R7)
    for (int i = 0; i < NVEC; i++) begin
      logic isW, pv;
      logic [11:0] a;
      logic [31:0] d;
      {isW, pv, a, d} = VEC[i];
      busOp(isW, pv, a, d, rd);
      if (!isW)
        check(rd == d, $sformatf("R2-R7 vector %0d rdata", i), 134'(rd), 134'(d));
      check(accErr == !pv, $sformatf("R7 vector %0d accErr", i),
            134'(accErr), 134'(!pv));
    end
    // R7: pulse lasts one cycle only
    @(negedge clk);
    check(accErr == 1'b0, "R7 accErr one cycle", 134'(accErr), '0);

    // clear every line for the pending tests
    for (int k = 0; k < 5; k++) wr(12'h180 + 12'(4 * k), 32'hFFFF_FFFF);
    check(eligible == '0, "R9 all disabled", eligible, '0);

    // R8: a disabled line becomes pending but is not eligible
    @(negedge clk); irqIn[5] = 1'b1;
    @(negedge clk);
    check(eligible == '0, "R8 disabled pending not eligible", eligible, '0);
    // R9: enabling the pending line makes it eligible
    wr(12'h100, 32'h0000_0020);
    check(eligible == bitAt(5), "R9 enable pending line", eligible, bitAt(5));

    // R10: acknowledge clears pending; held-high input does not re-pend (R8)
    @(negedge clk); ackValid = 1'b1; ackId = 8'd5;
    @(negedge clk); ackValid = 1'b0;
    check(eligible == '0, "R10 ack clears pending", eligible, '0);
    repeat (3) @(negedge clk);
    check(eligible == '0, "R8 level does not re-pend", eligible, '0);

    // R6/R8: highest line 133
    wr(12'h110, 32'h0000_0020);
    @(negedge clk); irqIn[133] = 1'b1;
    @(negedge clk);
    check(eligible == bitAt(133), "R8 line 133 pending", eligible, bitAt(133));
    irqIn[133] = 1'b0;
    @(negedge clk);
    check(eligible == bitAt(133), "R8 pending survives input fall",
          eligible, bitAt(133));

    // R10: ack in the same cycle as a new rising edge keeps it pending
    irqIn[133] = 1'b1; ackValid = 1'b1; ackId = 8'd133;
    @(negedge clk); ackValid = 1'b0;
    check(eligible == bitAt(133), "R10 edge beats ack", eligible, bitAt(133));

    // R9: disabling hides, re-enabling restores the still-pending line
    wr(12'h190, 32'h0000_0020);
    check(eligible == '0, "R9 disabled hides pending", eligible, '0);
    wr(12'h110, 32'h0000_0020);
    check(eligible == bitAt(133), "R9 re-enable restores", eligible, bitAt(133));

    // R1: reset again clears everything
    @(negedge clk); rstN = 1'b0; irqIn = '0;
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check(eligible == '0, "R1 eligible after second reset", eligible, '0);
    busOp(1'b0, 1'b1, 12'h110, '0, rd);
    check(rd == '0, "R1 enables after second reset", 134'(rd), '0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule